// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Path

This block models a synchronous single-port memory. Inputs are registered and read data passes through an output register. Each word has two 9-bit lanes. A lane holds 8 data bits and 1 parity bit. The address, the three chip selects, the write strobes and the write data are all captured on the rising clock edge. The captured operation executes on the following edge.

Writes are done per lane. Each lane has its own select, qualified by a shared lane-write enable. A global write strobe overrides these and writes the whole word. A selected cycle with no lane write active is a read. Read data appears on the outputs one cycle after the read is captured.

An asynchronous output enable gates the output-drive flag. The flag is also held low in the cycle after a deselected cycle or a write is executed. This masks the first clock of a read that follows a deselected state. Burst address sequencing is outside the block: the caller presents each address directly.

Top module: `burst_sram_core`

## Requirements
- R1: Inputs are sampled on the rising edge. A selected read captured at edge k drives its word on `rdData`/`rdPar` after edge k+1. Reads on consecutive cycles stream one word per cycle.
- R2: The device is selected only when `selAN` is 0, `selB` is 1 and `selCN` is 0. Any other combination performs neither a write nor a read.
- R3: With `wrAllN` high, lane i is written only when `laneWrEnN` is 0 and `laneSelN[i]` is 0. The other lane keeps its stored value.
- R4: When `wrAllN` is 0, both lanes are written, whatever `laneWrEnN` and `laneSelN` are.
- R5: Lane 0 holds `wrData[7:0]` with `wrPar[0]`. Lane 1 holds `wrData[15:8]` with `wrPar[1]`.
- R6: When `wrAllN` and `laneWrEnN` are both 1, `laneSelN` is ignored and the selected cycle is a read.
- R7: `outEnN` acts without a clock. While it is 1, `dataDrive` is 0.
- R8: `dataDrive` is 1 only in the cycle that follows the execution of a selected read. After a deselected or write cycle executes, it is 0. This masks the first clock of a read that follows a deselected state.
- R9: A write captured at edge k followed by a read of the same address at edge k+1 returns the newly written word.
- R10: When a deselected cycle executes, the output register keeps its previous value and `dataDrive` is 0.
- R11: While `rstN` is 0, `rdData` and `rdPar` are 0 and `dataDrive` is 0. This takes effect without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| selAN | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| wrAllN | input | 1 | Global write, active low, writes every lane |
| laneWrEnN | input | 1 | Lane-write enable, active low |
| laneSelN | input | LANES | Per-lane write select, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| wrData | input | LANES*BYTE_W | Write data |
| wrPar | input | LANES | Write parity, one bit per lane |
| rdData | output | LANES*BYTE_W | Output register data |
| rdPar | output | LANES | Output register parity |
| dataDrive | output | 1 | High when the outputs are driven |

## Verification
Lane writes are tried with only lane 0, only lane 1, both lanes through the lane enable, and the global strobe with the lane controls both asserted and released. Different byte and parity patterns are used, so a swapped lane, a lost parity bit or a missed override shows up as a distinct wrong word. A cycle with lane selects low but the lane enable high must read rather than write.

Each chip select is released on its own during a write to show that it alone blocks the write. Read timing is probed as:
- a read following a deselected cycle, to catch a missing mask;
- back-to-back reads, to check one-word-per-cycle streaming;
- a write followed at once by a read of the same address;
- toggling the output enable between edges, to check that it acts without a clock.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  // Strobes from the control path to the datapath for the operation
  // executing at the current edge.
  typedef struct packed {
    logic execWrite;
    logic execRead;
  } bsram_strobe_t;

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selAN,
  input  logic             selB,
  input  logic             selCN,
  input  logic             wrAllN,
  input  logic             laneWrEnN,
  input  logic [LANES-1:0] laneSelN,
  input  logic             outEnN,
  output bsram_strobe_t    strobe,
  output logic [LANES-1:0] laneMask,
  output logic             dataDrive
);

  logic             selNow;
  logic [LANES-1:0] laneReq;
  logic             selQ;
  logic [LANES-1:0] laneQ;
  logic             driveQ;

  assign selNow = ~selAN & selB & ~selCN;

  for (genvar g = 0; g < LANES; g++) begin : g_laneReq
    assign laneReq[g] = ~wrAllN | (~laneWrEnN & ~laneSelN[g]);
  end

  // Input register stage: capture the decoded request.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      laneQ <= '0;
    end else begin
      selQ  <= selNow;
      laneQ <= laneReq;
    end
  end

  always_comb begin
    strobe.execWrite = selQ & (|laneQ);
    strobe.execRead  = selQ & ~(|laneQ);
  end
  assign laneMask = laneQ;

  // The drive flag follows the operation executed at each edge. Only a
  // read enables output, which masks the first read after deselect.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) driveQ <= 1'b0;
    else       driveQ <= strobe.execRead;
  end

  assign dataDrive = ~outEnN & driveQ;

endmodule

// File: rtl/bsram_dp.sv
module bsram_dp
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*BYTE_W-1:0] wrData,
  input  logic [LANES-1:0]        wrPar,
  input  bsram_strobe_t           strobe,
  input  logic [LANES-1:0]        laneMask,
  output logic [LANES*BYTE_W-1:0] rdData,
  output logic [LANES-1:0]        rdPar
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = BYTE_W + 1;

  logic [ADDR_W-1:0]       addrQ;
  logic [LANES*BYTE_W-1:0] dataQ;
  logic [LANES-1:0]        parQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      parQ  <= '0;
    end else begin
      addrQ <= addr;
      dataQ <= wrData;
      parQ  <= wrPar;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneOut;

    always_ff @(posedge clk) begin
      if (strobe.execWrite && laneMask[g])
        laneMem[addrQ] <= {parQ[g], dataQ[g*BYTE_W +: BYTE_W]};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                laneOut <= '0;
      else if (strobe.execRead) laneOut <= laneMem[addrQ];
    end

    assign rdData[g*BYTE_W +: BYTE_W] = laneOut[BYTE_W-1:0];
    assign rdPar[g]                   = laneOut[BYTE_W];
  end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    selAN,
  input  logic                    selB,
  input  logic                    selCN,
  input  logic                    wrAllN,
  input  logic                    laneWrEnN,
  input  logic [LANES-1:0]        laneSelN,
  input  logic                    outEnN,
  input  logic [LANES*BYTE_W-1:0] wrData,
  input  logic [LANES-1:0]        wrPar,
  output logic [LANES*BYTE_W-1:0] rdData,
  output logic [LANES-1:0]        rdPar,
  output logic                    dataDrive
);

  bsram_strobe_t    strobe;
  logic [LANES-1:0] laneMask;

  bsram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .selAN(selAN), .selB(selB), .selCN(selCN),
    .wrAllN(wrAllN), .laneWrEnN(laneWrEnN), .laneSelN(laneSelN),
    .outEnN(outEnN), .strobe(strobe), .laneMask(laneMask),
    .dataDrive(dataDrive)
  );

  bsram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrPar(wrPar),
    .strobe(strobe), .laneMask(laneMask), .rdData(rdData), .rdPar(rdPar)
  );

endmodule

// File: rtl/bsram_checker.sv
module bsram_checker #(
  parameter int LANES  = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              selAN,
  input logic              selB,
  input logic              selCN,
  input logic              wrAllN,
  input logic              laneWrEnN,
  input logic [LANES-1:0]  laneSelN,
  input logic              outEnN,
  input logic [DATA_W-1:0] rdData,
  input logic [LANES-1:0]  rdPar,
  input logic              dataDrive
);

  logic chipOn;
  logic isRead;
  assign chipOn = !selAN && selB && !selCN;
  assign isRead = wrAllN && (laneWrEnN || (&laneSelN));

  // R7: the enable pin alone forces the outputs undriven
  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataDrive);

  // R1 and R6: a selected read two edges back drives data
  assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chipOn, 2) && $past(isRead, 2) && !outEnN) |-> dataDrive);

  // R8: a write two edges back leaves the outputs undriven
  assert_write_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chipOn, 2) && !$past(isRead, 2)) |-> !dataDrive);

  // R10: a deselected cycle keeps the output register and drives nothing
  assert_desel_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(chipOn, 2) |-> (!dataDrive && $stable(rdData) && $stable(rdPar)));

  // R11: reset clears the output register
  assert_reset_clear_R11: assert property (@(posedge clk)
    !rstN |=> (rdData == '0 && rdPar == '0 && !dataDrive));

endmodule

bind burst_sram_core bsram_checker #(.LANES(LANES), .DATA_W(LANES*BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .selAN(selAN), .selB(selB), .selCN(selCN),
  .wrAllN(wrAllN), .laneWrEnN(laneWrEnN), .laneSelN(laneSelN),
  .outEnN(outEnN), .rdData(rdData), .rdPar(rdPar), .dataDrive(dataDrive)
);

// File: tb/test_burst_sram_core.sv
module test_burst_sram_core;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  addr;
  logic        selAN, selB, selCN, wrAllN, laneWrEnN, outEnN;
  logic [1:0]  laneSelN, wrPar, rdPar;
  logic [15:0] wrData, rdData;
  logic        dataDrive;

  int tests = 0;
  int failed = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram_core i_burst_sram_core (
    .clk(clk), .rstN(rstN), .addr(addr), .selAN(selAN), .selB(selB),
    .selCN(selCN), .wrAllN(wrAllN), .laneWrEnN(laneWrEnN),
    .laneSelN(laneSelN), .outEnN(outEnN), .wrData(wrData), .wrPar(wrPar),
    .rdData(rdData), .rdPar(rdPar), .dataDrive(dataDrive)
  );

  // isRd marks rows whose data/par fields are also the expected read.
  typedef struct packed {
    logic        isRd;
    logic        gw;
    logic        bwe;
    logic [1:0]  bw;
    logic [5:0]  a;
    logic [15:0] d;
    logic [1:0]  p;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b1, 2'b11, 6'd5,  16'hA55A, 2'b10},
    '{1'b1, 1'b1, 1'b1, 2'b11, 6'd5,  16'hA55A, 2'b10},
    '{1'b0, 1'b1, 1'b0, 2'b10, 6'd5,  16'h1234, 2'b01},
    '{1'b1, 1'b1, 1'b1, 2'b11, 6'd5,  16'hA534, 2'b11},
    '{1'b0, 1'b1, 1'b0, 2'b01, 6'd5,  16'hFFEE, 2'b00},
    '{1'b1, 1'b1, 1'b1, 2'b11, 6'd5,  16'hFF34, 2'b01},
    '{1'b1, 1'b1, 1'b1, 2'b00, 6'd5,  16'hFF34, 2'b01},
    '{1'b0, 1'b0, 1'b0, 2'b11, 6'd9,  16'h0F0F, 2'b11},
    '{1'b1, 1'b1, 1'b1, 2'b11, 6'd9,  16'h0F0F, 2'b11},
    '{1'b0, 1'b0, 1'b1, 2'b11, 6'd63, 16'hBEEF, 2'b01},
    '{1'b1, 1'b1, 1'b1, 2'b11, 6'd63, 16'hBEEF, 2'b01},
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'd0,  16'h8001, 2'b10},
    '{1'b1, 1'b1, 1'b1, 2'b11, 6'd0,  16'h8001, 2'b10},
    '{1'b1, 1'b1, 1'b1, 2'b11, 6'd5,  16'hFF34, 2'b01}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic a1, input logic b, input logic c3, input logic g,
                       input logic bwe, input logic [1:0] bw, input logic [5:0] a,
                       input logic [15:0] d, input logic [1:0] p);
    selAN = a1; selB = b; selCN = c3; wrAllN = g; laneWrEnN = bwe;
    laneSelN = bw; addr = a; wrData = d; wrPar = p;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 6'd0, 16'h0, 2'b00);
  endtask

  task automatic rd(input logic [5:0] a);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, a, 16'h0, 2'b00);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    outEnN = 1'b0;
    idle();
    repeat (3) step();
    check("R11 reset data", {16'h0, rdData}, 32'h0);
    check("R11 reset drive", {31'h0, dataDrive}, 32'h0);
    rstN = 1'b1;
    step();

    // Table: each row is captured, executed during one idle cycle, then checked.
    for (int i = 0; i < NVEC; i++) begin
      drive(1'b0, 1'b1, 1'b0, VECS[i].gw, VECS[i].bwe, VECS[i].bw, VECS[i].a,
            VECS[i].d, VECS[i].p);
      step();
      idle();
      step();
      if (VECS[i].isRd) begin
        check($sformatf("R1/R3/R4/R5/R6 row %0d drive", i), {31'h0, dataDrive}, 32'h1);
        check($sformatf("R3/R4/R5/R6 row %0d word", i), {14'h0, rdPar, rdData},
              {14'h0, VECS[i].p, VECS[i].d});
      end else begin
        check($sformatf("R8 row %0d write undriven", i), {31'h0, dataDrive}, 32'h0);
      end
    end

    // R7: output enable acts between edges
    rd(6'd9); step(); idle(); step();
    outEnN = 1'b1; #1;
    check("R7 oe high", {31'h0, dataDrive}, 32'h0);
    outEnN = 1'b0; #1;
    check("R7 oe low", {31'h0, dataDrive}, 32'h1);
    step();

    // R8 mask after deselect, R1 back-to-back reads, R10 hold
    rd(6'd63); step();
    check("R8 first read after deselect masked", {31'h0, dataDrive}, 32'h0);
    rd(6'd0); step();
    check("R1 first of stream", {14'h0, rdPar, rdData}, {14'h0, 2'b01, 16'hBEEF});
    idle(); step();
    check("R1 second of stream", {14'h0, rdPar, rdData}, {14'h0, 2'b10, 16'h8001});
    step();
    check("R10 deselect undriven", {31'h0, dataDrive}, 32'h0);
    check("R10 deselect holds", {14'h0, rdPar, rdData}, {14'h0, 2'b10, 16'h8001});

    // R2: each select alone blocks a global write to address 9
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd9, 16'h0000, 2'b00); step();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd9, 16'h0000, 2'b00); step();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 6'd9, 16'h0000, 2'b00); step();
    rd(6'd9); step(); idle(); step();
    check("R2 deselected writes ignored", {14'h0, rdPar, rdData}, {14'h0, 2'b11, 16'h0F0F});

    // R9: write then immediate read of same address
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 6'd12, 16'h5A5A, 2'b11); step();
    rd(6'd12); step();
    idle(); step();
    check("R9 write then read", {14'h0, rdPar, rdData}, {14'h0, 2'b11, 16'h5A5A});
    check("R9 drive", {31'h0, dataDrive}, 32'h1);

    // R11: asynchronous reset mid-run
    #1 rstN = 1'b0; #1;
    check("R11 async reset data", {14'h0, rdPar, rdData}, 32'h0);
    check("R11 async reset drive", {31'h0, dataDrive}, 32'h0);
    repeat (3) step();
    rstN = 1'b1;
    step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule